// File: doc/BRIEF.md
# DRAM Page-Mode Access Controller

This block sits between a simple host request port and a 16-bit-wide DRAM array. Each host request carries a byte address, write data, two byte enables and a read/write flag. The block turns it into a multiplexed DRAM cycle: it puts a row address on a shared address bus, asserts the row strobe, then puts a column address on the same bus and asserts the column strobes. It drives separate upper and lower column strobes, so byte writes and byte reads need no extra logic on the array side. Reads assert the output enable and writes assert the write enable.

When page mode is on, the block leaves the row open after an access. It compares the row of the next request with the open row. On a hit it runs only the two-state column phase and keeps the row strobe low. On a miss, or when no request follows, it closes the row with one precharge state. A three-bit shift code sets where the address is split into row and column. The host holds a request and its fields steady until `ready_o` pulses. It may present the next request in the cycle right after that pulse.

Top module: `dram_page_ctrl`

## Requirements
- R1: While `rst_ni` is low, `ras_no`, `ucas_no`, `lcas_no`, `we_no` and `oe_no` are high, `ready_o` is low and `dq_oe_o` is low.
- R2: A request that arrives while no row is open produces `ready_o` four cycles after it is first seen. The sequence is two row states (`ma_o` shows the row, and `ras_no` falls in the second) followed by two column states.
- R3: The column phase lasts two states. `ma_o` shows the column in both, the column strobes go low only in the second, and `ready_o` is high for exactly that second state.
- R4: With `cfg_burst_i`=1, a request presented right after `ready_o` whose row equals the open row gets its `ready_o` two cycles after the previous one, and `ras_no` stays low throughout.
- R5: With `cfg_burst_i`=0, `ras_no` rises in the cycle after every `ready_o`. A request presented at once gets its `ready_o` five cycles after the previous one.
- R6: With `cfg_burst_i`=1, a request presented right after `ready_o` whose row differs from the open row gets its `ready_o` six cycles after the previous one. This covers one open-row check, one precharge state and a full access.
- R7: `cfg_shift_i` codes 0, 1, 2 and 3 select shift sizes s = 8, 9, 10 and 11. Codes 4 to 7 select s = 8. The word address is `addr_i` >> 1. The column is its low s bits and the row is the word address >> s. Both are driven on `ma_o` (11 bits) with the upper bits zero, and the row used in the page-hit compare is the full row.
- R8: In the second column state, `ucas_no` is low exactly when `be_i[1]` is 1 (data bits 15..8), and `lcas_no` is low exactly when `be_i[0]` is 1 (data bits 7..0).
- R9: For a read (`wr_i`=0), `oe_no` is low in both column states. `rdata_o` equals `dq_i` in the cycle `ready_o` is high.
- R10: For a write (`wr_i`=1), `we_no` is low and `dq_oe_o` is high in both column states, and `dq_o` equals `wdata_i`.
- R11: With a row open and no request in the cycle after `ready_o`, `ras_no` is still low that cycle and high in the next. Every rise of `ras_no` is followed by at least one further cycle with `ras_no` high.
- R12: `we_no` and `oe_no` are never low together, and a column strobe is never low while `ras_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_burst_i | input | 1 | Page mode enable |
| cfg_shift_i | input | 3 | Row/column split code |
| req_i | input | 1 | Host request valid |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte address |
| be_i | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| wdata_i | input | 16 | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with `ready_o` |
| ma_o | output | 11 | Multiplexed row/column address |
| ras_no | output | 1 | Row strobe, active low |
| ucas_no | output | 1 | Upper-byte column strobe, active low |
| lcas_no | output | 1 | Lower-byte column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| oe_no | output | 1 | Output enable, active low |
| dq_o | output | 16 | Data to the array |
| dq_oe_o | output | 1 | Data output enable |
| dq_i | input | 16 | Data from the array |

## Verification
The hardest situation to reach is the open-row decision. It happens in the single cycle after `ready_o`, and its outcome depends on the shift code, the burst setting and whether the host has a new request waiting at that moment. The bench issues each follow-up request in the same half cycle in which it sees `ready_o`. It builds addresses from a row and a column so that hit, miss and idle follow-ups occur under every shift code. It then times each access by counting cycles and checks the row and column bits against a data pattern the array model derives from the strobed addresses.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW_A,
    ST_ROW_B,
    ST_COL_A,
    ST_COL_B,
    ST_OPEN
  } dram_st_e;
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ADDR_W     = 24,
  parameter int BASE_SHIFT = 8,
  parameter int N_SHIFT    = 4,
  parameter int MA_W       = BASE_SHIFT + N_SHIFT - 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        shift_code_i,
  output logic [ADDR_W-1:0] row_o,
  output logic [MA_W-1:0]   col_o
);
  localparam int IW = (N_SHIFT > 1) ? $clog2(N_SHIFT) : 1;

  logic [ADDR_W-1:0] word;
  logic [ADDR_W-1:0] row_v [N_SHIFT];
  logic [MA_W-1:0]   col_v [N_SHIFT];
  logic [IW-1:0]     idx;

  assign word = addr_i >> 1;

  for (genvar g = 0; g < N_SHIFT; g++) begin : g_shift
    localparam int S = BASE_SHIFT + g;
    assign row_v[g] = word >> S;
    assign col_v[g] = MA_W'(word[S-1:0]);
  end

  // out-of-range codes fall back to the smallest split
  always_comb begin
    if (int'(shift_code_i) < N_SHIFT) idx = IW'(shift_code_i);
    else                              idx = '0;
  end

  assign row_o = row_v[idx];
  assign col_o = col_v[idx];
endmodule

// File: rtl/dram_row_track.sv
module dram_row_track #(
  parameter int ROW_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             hit_o
);
  logic [ROW_W-1:0] open_row_q;
  logic             open_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_row_q <= '0;
      open_vld_q <= 1'b0;
    end else if (load_i) begin
      open_row_q <= row_i;
      open_vld_q <= 1'b1;
    end else if (clear_i) begin
      open_vld_q <= 1'b0;
    end
  end

  assign hit_o = open_vld_q && (open_row_q == row_i);
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_page_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  logic     burst_i,
  input  logic     hit_i,
  output dram_st_e st_o,
  output logic     col_first_o
);
  dram_st_e st_q, st_d;
  logic     page_go;

  // open row reused as the first column state
  assign page_go = (st_q == ST_OPEN) && req_i && burst_i && hit_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_i) st_d = ST_ROW_A;
      ST_PRE:   st_d = req_i ? ST_ROW_A : ST_IDLE;
      ST_ROW_A: st_d = ST_ROW_B;
      ST_ROW_B: st_d = ST_COL_A;
      ST_COL_A: st_d = ST_COL_B;
      ST_COL_B: st_d = burst_i ? ST_OPEN : ST_PRE;
      ST_OPEN:  st_d = page_go ? ST_COL_B : ST_PRE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o        = st_q;
  assign col_first_o = (st_q == ST_COL_A) || page_go;
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_page_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int BASE_SHIFT = 8,
  parameter int N_SHIFT    = 4,
  parameter int MA_W       = BASE_SHIFT + N_SHIFT - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_burst_i,
  input  logic [2:0]        cfg_shift_i,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MA_W-1:0]   ma_o,
  output logic              ras_no,
  output logic              ucas_no,
  output logic              lcas_no,
  output logic              we_no,
  output logic              oe_no,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  logic [ADDR_W-1:0] row;
  logic [MA_W-1:0]   col;
  logic              hit;
  logic              col_first;
  logic              col_phase;
  logic              row_phase;
  logic              strobe;
  dram_st_e          st;

  dram_addr_split #(
    .ADDR_W    (ADDR_W),
    .BASE_SHIFT(BASE_SHIFT),
    .N_SHIFT   (N_SHIFT),
    .MA_W      (MA_W)
  ) u_split (
    .addr_i      (addr_i),
    .shift_code_i(cfg_shift_i),
    .row_o       (row),
    .col_o       (col)
  );

  dram_row_track #(.ROW_W(ADDR_W)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (st == ST_ROW_A),
    .clear_i((st == ST_PRE) || (st == ST_IDLE)),
    .row_i  (row),
    .hit_o  (hit)
  );

  dram_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .burst_i    (cfg_burst_i),
    .hit_i      (hit),
    .st_o       (st),
    .col_first_o(col_first)
  );

  assign row_phase = (st == ST_ROW_A) || (st == ST_ROW_B);
  assign col_phase = col_first || (st == ST_COL_B);
  assign strobe    = (st == ST_COL_B);

  always_comb begin
    if (row_phase)      ma_o = MA_W'(row);
    else if (col_phase) ma_o = col;
    else                ma_o = '0;
  end

  assign ras_no  = !((st == ST_ROW_B) || (st == ST_COL_A) ||
                     (st == ST_COL_B) || (st == ST_OPEN));
  assign ucas_no = !(strobe && be_i[1]);
  assign lcas_no = !(strobe && be_i[0]);
  assign we_no   = !(col_phase && wr_i);
  assign oe_no   = !(col_phase && !wr_i);
  assign dq_oe_o = col_phase && wr_i;
  assign dq_o    = wdata_i;
  assign ready_o = strobe;
  assign rdata_o = (strobe && !wr_i) ? dq_i : '0;
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_burst_i,
  input logic [1:0] be_i,
  input logic       ready_o,
  input logic       ras_no,
  input logic       ucas_no,
  input logic       lcas_no,
  input logic       we_no,
  input logic       oe_no,
  input logic       dq_oe_o
);
  AST_CAS_UNDER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ucas_no || !lcas_no) |-> !ras_no); // R12
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no)); // R12
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R3
  AST_COL_ADDR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(!we_no || !oe_no)); // R3
  AST_PRECHARGE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |=> ras_no); // R11
  AST_CLOSE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !cfg_burst_i) |=> ras_no); // R5
  AST_UPPER_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ucas_no |-> be_i[1]); // R8
  AST_LOWER_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcas_no |-> be_i[0]); // R8
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !we_no); // R10
endmodule

bind dram_page_ctrl dram_page_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_burst_i(cfg_burst_i),
  .be_i       (be_i),
  .ready_o    (ready_o),
  .ras_no     (ras_no),
  .ucas_no    (ucas_no),
  .lcas_no    (lcas_no),
  .we_no      (we_no),
  .oe_no      (oe_no),
  .dq_oe_o    (dq_oe_o)
);

// File: tb/sim_dram_page_ctrl.sv
module sim_dram_page_ctrl;
  localparam int ADDR_W = 24;
  localparam int MA_W   = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_burst = 1'b0;
  logic [2:0]        cfg_shift = '0;
  logic              req = 1'b0;
  logic              wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0]        be = '0;
  logic [15:0]       wdata = '0;
  logic              ready_o;
  logic [15:0]       rdata_o;
  logic [MA_W-1:0]   ma_o;
  logic              ras_no, ucas_no, lcas_no, we_no, oe_no, dq_oe_o;
  logic [15:0]       dq_o, dq_i;
  logic [MA_W-1:0]   row_seen = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dram_page_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_burst_i(cfg_burst), .cfg_shift_i(cfg_shift),
    .req_i(req), .wr_i(wr), .addr_i(addr), .be_i(be), .wdata_i(wdata),
    .ready_o(ready_o), .rdata_o(rdata_o), .ma_o(ma_o), .ras_no(ras_no),
    .ucas_no(ucas_no), .lcas_no(lcas_no), .we_no(we_no), .oe_no(oe_no),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i)
  );

  // array model: read pattern built from strobed row and current column
  always @(negedge ras_no) row_seen = ma_o;
  assign dq_i = !oe_no ? {row_seen[7:0] ^ 8'hA5, ma_o[7:0]} : 16'h0000;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input int s, input int r, input int c);
    logic [ADDR_W-1:0] w;
    w = (ADDR_W'(r) << s) | ADDR_W'(c);
    return w << 1;
  endfunction

  task automatic access(input logic [ADDR_W-1:0] a, input bit w, input logic [1:0] b,
                        input logic [15:0] wd, input int s, input int exp_lat,
                        input string tag);
    int n;
    bit ras_hi;
    bit cas_early;
    logic [ADDR_W-1:0] wa;
    logic [MA_W-1:0] rowe, cole;
    req = 1'b1; addr = a; wr = w; be = b; wdata = wd;
    n = 0; ras_hi = 0; cas_early = 0;
    forever begin
      @(negedge clk);
      n++;
      if (ready_o || n >= 20) break;
      if (ras_no) ras_hi = 1;
      if (!ucas_no || !lcas_no) cas_early = 1;
    end
    wa   = a >> 1;
    rowe = MA_W'(wa >> s);
    cole = MA_W'(wa & ((ADDR_W'(1) << s) - 1));
    chk(n == exp_lat, {tag, " latency"}, n, exp_lat);
    if (exp_lat == 2) chk(!ras_hi, "R4 row held", ras_hi, 0);
    chk(!cas_early, "R3 cas only in second column state", cas_early, 0);
    chk(ma_o == cole, "R7 column on ma", ma_o, cole);
    chk(ucas_no == !b[1] && lcas_no == !b[0], "R8 byte strobes",
        {ucas_no, lcas_no}, {!b[1], !b[0]});
    if (!w) begin
      chk(!oe_no && we_no, "R9 oe active", {oe_no, we_no}, 2'b01);
      chk(rdata_o == {rowe[7:0] ^ 8'hA5, cole[7:0]}, "R7 R9 read data",
          rdata_o, {rowe[7:0] ^ 8'hA5, cole[7:0]});
    end else begin
      chk(!we_no && oe_no && dq_oe_o && dq_o == wd, "R10 write drive",
          {we_no, oe_no, dq_oe_o, dq_o}, {3'b011, wd});
    end
  endtask

  task automatic go_idle(input bit burst_on);
    req = 1'b0;
    @(negedge clk);
    if (burst_on) begin
      chk(!ras_no, "R11 row still open", ras_no, 0);
      @(negedge clk);
      chk(ras_no, "R11 precharge", ras_no, 1);
    end else begin
      chk(ras_no, "R5 row closed", ras_no, 1);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_no && ucas_no && lcas_no && we_no && oe_no && !ready_o && !dq_oe_o,
        "R1 reset state", {ras_no, ucas_no, lcas_no, we_no, oe_no, ready_o, dq_oe_o},
        7'b1111100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int code = 0; code < 8; code++) begin
      int s, r, cmax, cmid;
      s    = (code < 4) ? 8 + code : 8;
      r    = 3 + code;
      cmax = (1 << s) - 1;
      cmid = 5 + code;
      cfg_shift = 3'(code);
      cfg_burst = 1'b1;
      access(mk_addr(s, r, cmax), 0, 2'b11, 16'h0, s, 4, "R2 full read");
      access(mk_addr(s, r, 0), 1, 2'b01, 16'h1234 + 16'(code), s, 2, "R4 hit write");
      access(mk_addr(s, r, cmid), 0, 2'b10, 16'h0, s, 2, "R4 hit read");
      access(mk_addr(s, r + 1, cmid), 1, 2'b10, 16'hBEEF, s, 6, "R6 miss write");
      go_idle(1'b1);
      cfg_burst = 1'b0;
      access(mk_addr(s, r, 0), 0, 2'b11, 16'h0, s, 4, "R2 full read off");
      access(mk_addr(s, r, cmid), 0, 2'b01, 16'h0, s, 5, "R5 same row off");
      go_idle(1'b0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule